// File: doc/BRIEF.md
# Nanosecond-Period Fractional Baud Generator

This block produces the 16x oversampling strobe for a 16550-style serial port. Software does not program a divisor counted in reference clocks. It programs the length of one sample period in nanoseconds, with a fractional part in steps of 1/255 ns. The generator runs from a fixed 62.5 MHz reference, so each reference cycle is worth exactly 16 ns.

A phase accumulator adds 16 ns on every enabled cycle. When the accumulated time reaches the programmed period, the generator emits a one-cycle sample strobe and subtracts the period. The remainder stays in the accumulator, so rounding errors never build up over time. A counter of sample strobes emits a bit-time strobe on every sixteenth sample.

The divisor write and the enable are plain control pins. There is no data stream, so the block has no valid/ready handshake. The two strobes are single-cycle pulses that are registered at the output.

Top module: `nsbaud_gen`

## Requirements
- R1: The 32-bit divisor word carries the integer sample period in nanoseconds in bits 31:8. Bits 7:0 carry a fractional part, where a value x adds x/255 ns. The programmed period in 1/255 ns units is therefore I*255+F.
- R2: Each enabled reference cycle without a write adds 16 ns (4080 units) to the accumulator. If the sum reaches or exceeds the period, sample_tick_o is high for the cycle after that edge and the period is subtracted, keeping the remainder. After n enabled cycles from a cleared state, exactly floor(n*4080/P) sample strobes have occurred.
- R3: bit_tick_o pulses together with every 16th sample strobe counted since the last write or reset, and at no other time.
- R4: A divisor write clears the accumulator and the sample count, and the new period applies from the next cycle. No strobe appears in the cycle that follows the write edge, even when enable is high.
- R5: While enable_i is low and no write occurs, the accumulator and the sample count hold their values and both strobes stay low. When enable_i returns high, counting resumes from the held phase.
- R6: An integer field below 16 is replaced by exactly 16.0 ns, with the fraction dropped. At this period the generator strobes on every enabled cycle.
- R7: A fraction field of 255 is treated as 254.
- R8: After reset both strobes are low, the accumulator and the sample count are zero, and the divisor holds the RESET_DIV default (542 + 136/255 ns).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 62.5 MHz reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Advance the accumulator on this cycle |
| div_we_i | input | 1 | Divisor write strobe |
| div_wdata_i | input | 32 | Divisor word: integer ns in bits 31:8, fraction in bits 7:0 |
| sample_tick_o | output | 1 | One-cycle 16x sample strobe |
| bit_tick_o | output | 1 | One-cycle strobe on every 16th sample |

## Verification
The bench goes after the fractional borrow. A subtraction that drops the borrow would drift, and the strobe totals over long windows would diverge from floor(n*4080/P). The clamp is checked with tiny and zero integer fields. A generator without the clamp would skip strobes, or try to fire twice in one cycle. Fraction 255 is checked because an unsaturated field would run slightly slow. The bench also writes while ticking every cycle, and pauses enable mid-period. These catch a clear that leaks a strobe, and a pause that loses or advances the phase. The bit strobe is compared on every cycle, which exposes an off-by-one in the sample counter.

// File: rtl/nsbaud_pkg.sv
package nsbaud_pkg;
  localparam int DIV_W  = 32;
  localparam int FRAC_W = 8;
  localparam int INT_W  = DIV_W - FRAC_W;

  typedef struct packed {
    logic [INT_W-1:0]  ns;
    logic [FRAC_W-1:0] frac;
  } period_t;
endpackage

// File: rtl/nsbaud_div_reg.sv
module nsbaud_div_reg
  import nsbaud_pkg::*;
#(
  parameter logic [DIV_W-1:0] RESET_DIV = 32'h0002_1E88,
  parameter int               REF_NS    = 16,
  parameter int               FRAC_DEN  = 255
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [DIV_W-1:0] wdata_i,
  output period_t          period_o
);
  localparam logic [FRAC_W-1:0] FRAC_MAX = FRAC_W'(FRAC_DEN - 1);
  localparam logic [INT_W-1:0]  NS_MIN   = INT_W'(REF_NS);

  function automatic period_t legalize(input logic [DIV_W-1:0] raw);
    period_t p;
    p.ns   = raw[DIV_W-1:FRAC_W];
    p.frac = raw[FRAC_W-1:0];
    if (p.frac > FRAC_MAX) p.frac = FRAC_MAX;
    if (p.ns < NS_MIN) begin
      p.ns   = NS_MIN;
      p.frac = '0;
    end
    return p;
  endfunction

  localparam period_t RESET_PERIOD = legalize(RESET_DIV);

  period_t period_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) period_q <= RESET_PERIOD;
    else if (we_i) period_q <= legalize(wdata_i);
  end

  assign period_o = period_q;

  p_period_floor_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (period_q.ns >= NS_MIN));
  p_frac_sat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (period_q.frac <= FRAC_MAX));
endmodule

// File: rtl/nsbaud_phase.sv
module nsbaud_phase
  import nsbaud_pkg::*;
#(
  parameter int REF_NS   = 16,
  parameter int FRAC_DEN = 255
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    clear_i,
  input  logic    step_i,
  input  period_t period_i,
  output logic    hit_o,
  output logic    tick_o
);
  localparam int ACC_W = INT_W + 1;
  localparam logic [FRAC_W:0] DEN_X = (FRAC_W+1)'(FRAC_DEN);

  logic [ACC_W-1:0]  acc_int_q;
  logic [FRAC_W-1:0] acc_frac_q;
  logic              tick_q;

  logic [ACC_W-1:0]  sum_int;
  logic [ACC_W-1:0]  per_int;
  logic              reach;
  logic              borrow;
  logic [FRAC_W:0]   frac_wide;
  logic [FRAC_W-1:0] rem_frac;
  logic [ACC_W-1:0]  rem_int;

  always_comb begin
    sum_int   = acc_int_q + ACC_W'(REF_NS);
    per_int   = ACC_W'(period_i.ns);
    reach     = (sum_int > per_int) ||
                ((sum_int == per_int) && (acc_frac_q >= period_i.frac));
    borrow    = acc_frac_q < period_i.frac;
    frac_wide = borrow ? ({1'b0, acc_frac_q} + DEN_X - {1'b0, period_i.frac})
                       : ({1'b0, acc_frac_q} - {1'b0, period_i.frac});
    rem_frac  = frac_wide[FRAC_W-1:0];
    rem_int   = sum_int - per_int - ACC_W'(borrow);
  end

  assign hit_o = step_i && !clear_i && reach;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_int_q  <= '0;
      acc_frac_q <= '0;
      tick_q     <= 1'b0;
    end else if (clear_i) begin
      acc_int_q  <= '0;
      acc_frac_q <= '0;
      tick_q     <= 1'b0;
    end else if (step_i) begin
      if (reach) begin
        acc_int_q  <= rem_int;
        acc_frac_q <= rem_frac;
      end else begin
        acc_int_q  <= sum_int;
      end
      tick_q <= reach;
    end else begin
      tick_q <= 1'b0;
    end
  end

  assign tick_o = tick_q;

  p_frac_in_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_frac_q < FRAC_W'(FRAC_DEN));
  p_rem_below_period_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_int_q < per_int) ||
    ((acc_int_q == per_int) && (acc_frac_q < period_i.frac)));
  p_clear_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (!tick_q && (acc_int_q == '0) && (acc_frac_q == '0)));
  p_frozen_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !clear_i) |=> ($stable(acc_int_q) && $stable(acc_frac_q) && !tick_q));
endmodule

// File: rtl/nsbaud_bit_ctr.sv
module nsbaud_bit_ctr #(
  parameter int SAMPLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic hit_i,
  output logic bit_tick_o
);
  localparam int CNT_W = (SAMPLES > 1) ? $clog2(SAMPLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SAMPLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_next;
  logic             at_last;
  logic             bit_q;

  assign at_last = (cnt_q == LAST);

  generate
    if ((1 << CNT_W) == SAMPLES) begin : g_pow2
      assign cnt_next = cnt_q + 1'b1;
    end else begin : g_wrap
      assign cnt_next = at_last ? '0 : cnt_q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      bit_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q <= '0;
      bit_q <= 1'b0;
    end else if (hit_i) begin
      cnt_q <= cnt_next;
      bit_q <= at_last;
    end else begin
      bit_q <= 1'b0;
    end
  end

  assign bit_tick_o = bit_q;

  p_no_early_bit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && !clear_i && !at_last) |=> !bit_q);
  p_hold_count_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit_i && !clear_i) |=> $stable(cnt_q));
endmodule

// File: rtl/nsbaud_gen.sv
module nsbaud_gen
  import nsbaud_pkg::*;
#(
  parameter logic [31:0] RESET_DIV = 32'h0002_1E88,
  parameter int          REF_NS    = 16,
  parameter int          FRAC_DEN  = 255,
  parameter int          SAMPLES   = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        enable_i,
  input  logic        div_we_i,
  input  logic [31:0] div_wdata_i,
  output logic        sample_tick_o,
  output logic        bit_tick_o
);
  period_t period;
  logic    hit_now;

  nsbaud_div_reg #(
    .RESET_DIV (RESET_DIV),
    .REF_NS    (REF_NS),
    .FRAC_DEN  (FRAC_DEN)
  ) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (div_we_i),
    .wdata_i  (div_wdata_i),
    .period_o (period)
  );

  nsbaud_phase #(
    .REF_NS   (REF_NS),
    .FRAC_DEN (FRAC_DEN)
  ) u_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (div_we_i),
    .step_i   (enable_i),
    .period_i (period),
    .hit_o    (hit_now),
    .tick_o   (sample_tick_o)
  );

  nsbaud_bit_ctr #(
    .SAMPLES (SAMPLES)
  ) u_bits (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (div_we_i),
    .hit_i      (hit_now),
    .bit_tick_o (bit_tick_o)
  );

  p_bit_in_sample_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_o |-> sample_tick_o);
  p_write_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_we_i |=> (!sample_tick_o && !bit_tick_o));
  p_idle_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && !div_we_i) |=> (!sample_tick_o && !bit_tick_o));
endmodule

// File: tb/nsbaud_gen_tb_top.sv
module nsbaud_gen_tb_top;
  localparam int CLK_NS = 16;
  localparam int STEP_U = 16 * 255;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic        s_tick, b_tick;

  int checks = 0, fails = 0;
  longint tot_s = 0, tot_b = 0;
  longint m_per, m_acc;
  int     m_cnt;
  logic   exp_s = 1'b0, exp_b = 1'b0;
  logic   run_cmp = 1'b0;
  bit     done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  nsbaud_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .div_we_i(we),
    .div_wdata_i(wdata), .sample_tick_o(s_tick), .bit_tick_o(b_tick));

  // R1, R6, R7: period in 1/255 ns units from a divisor word
  function automatic longint units(input logic [31:0] d);
    longint i = longint'(d[31:8]);
    longint f = longint'(d[7:0]);
    if (f == 255) f = 254;
    if (i < 16) begin i = 16; f = 0; end
    return i * 255 + f;
  endfunction

  task automatic check(input string tag, input longint act, input longint expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  // Behavioural reference model, advanced on each edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_per = units(32'h0002_1E88); m_acc = 0; m_cnt = 0;
      exp_s = 0; exp_b = 0;
    end else if (we) begin
      m_per = units(wdata); m_acc = 0; m_cnt = 0;
      exp_s = 0; exp_b = 0;
    end else if (en) begin
      m_acc += STEP_U;
      if (m_acc >= m_per) begin
        m_acc -= m_per;
        exp_s = 1;
        exp_b = (m_cnt == 15);
        m_cnt = (m_cnt + 1) % 16;
      end else begin
        exp_s = 0; exp_b = 0;
      end
    end else begin
      exp_s = 0; exp_b = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && run_cmp) begin
      check("R2 sample strobe", longint'(s_tick), longint'(exp_s));
      check("R3 bit strobe", longint'(b_tick), longint'(exp_b));
      if (s_tick) tot_s++;
      if (b_tick) tot_b++;
    end
  end

  // write a divisor, enable, and count strobes over n cycles from a clear state
  task automatic prog_count(input logic [31:0] d, input int n, input string tag);
    longint s0, s1, b0, b1, p;
    @(negedge clk); we = 1; wdata = d;
    @(negedge clk); we = 0; en = 1;
    @(posedge clk); s0 = tot_s; b0 = tot_b;
    repeat (n) @(posedge clk);
    s1 = tot_s; b1 = tot_b;
    p = units(d);
    check(tag, s1 - s0, (longint'(n) * STEP_U) / p);
    check("R3 bit count", b1 - b0, ((longint'(n) * STEP_U) / p) / 16);
  endtask

  initial begin
    longint s0;
    repeat (3) @(negedge clk);
    check("R8 sample low in reset", longint'(s_tick), 0);
    check("R8 bit low in reset", longint'(b_tick), 0);
    rst_n = 1; run_cmp = 1;
    @(negedge clk);
    check("R8 sample low after reset", longint'(s_tick), 0);
    // R8/R1: default divisor rate, starting from reset-cleared accumulator
    en = 1;
    @(posedge clk); s0 = tot_s;
    repeat (4080) @(posedge clk);
    check("R8 default rate", tot_s - s0, (4080 * STEP_U) / units(32'h0002_1E88));
    // R1/R2: several periods
    prog_count(32'h0000_1400, 400, "R2 20.0ns count");
    prog_count(32'h0000_2A80, 1000, "R1 42.5ns count");
    prog_count(32'h0000_3001, 3000, "R2 48+1/255 count");
    // R7: fraction 255 saturates to 254
    prog_count(32'h0000_14FF, 6000, "R7 frac 255");
    // R6: clamp
    prog_count(32'h0000_0500, 64, "R6 clamp 5ns");
    prog_count(32'h0000_0000, 64, "R6 clamp zero");
    prog_count(32'h0000_0F80, 64, "R6 clamp 15.5ns");
    // R4: write while strobing every cycle
    @(negedge clk); we = 1; wdata = 32'h0000_1000;
    @(negedge clk); we = 0;
    check("R4 no strobe after write", longint'(s_tick), 0);
    @(negedge clk);
    check("R4 strobe resumes", longint'(s_tick), 1);
    // R4: write and enable together on a slower period
    @(negedge clk); we = 1; wdata = 32'h0000_1800;
    @(negedge clk); we = 0;
    check("R4 write with enable quiet", longint'(s_tick), 0);
    repeat (20) @(negedge clk);
    // R5: pause mid-period
    en = 0;
    @(posedge clk); s0 = tot_s;
    repeat (50) @(posedge clk);
    check("R5 paused strobes", tot_s - s0, 0);
    @(negedge clk); en = 1;
    repeat (200) @(negedge clk);
    en = 0; repeat (7) @(negedge clk); en = 1;
    repeat (300) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule